// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the two timing strobes a UART needs from one fixed reference clock. A phase accumulator adds a programmable multiplier on every reference cycle. Each time the running sum reaches a programmable divider, the accumulator subtracts the divider and emits a one-cycle sample strobe. The sample strobe therefore arrives at an average rate of Fref × MUL / DIV. A prescaler counter then counts the sample strobes and emits a bit strobe once every PS of them, so the bit rate is the sample rate divided by PS.

Software programs three registers over a 32-bit memory-mapped port and can read each one back. A write to any of the three restarts the accumulator and the prescaler from zero phase, so a new rate begins cleanly. When the configuration cannot produce a valid rate, the accumulator waits in a halted state and produces no strobes.

The accumulator is controlled by a two-state machine. In `ST_HALT` it holds the phase at zero. In `ST_RUN` it adds MUL on every cycle. The machine takes the transition HALT→RUN on the cycle after the configuration becomes valid. It takes RUN→HALT when the configuration is invalid. It takes ANY→HALT, the restart transition, on any register write.

Top module: `frac_baud_gen`

## Requirements
- R1: A write to byte offset 0x30 sets the prescaler (bits [15:0]). A write to 0x34 sets the multiplier and a write to 0x38 sets the divider (bits [23:0] each). A read of any of these offsets returns the last value written.
- R2: After a register write, the phase starts from zero. The first addition takes place on the second rising edge after the write edge. Over the next W additions, `sample_en` is high for exactly floor(W·MUL/DIV) cycles, each high period lasting one cycle.
- R3: `bit_en` pulses once for every PS effective sample strobes, counted from the last register write. After S sample strobes it has pulsed floor(S/PS) times.
- R4: `bit_en` is high only in a cycle where `sample_en` is also high. With PS = 1, every sample strobe is also a bit strobe.
- R5: A prescaler value of 0 behaves as 16. The register still reads back 0.
- R6: After reset, PS reads 16, MUL reads 1 and DIV reads 1. Both strobes are low while reset is held.
- R7: If MUL is 0, DIV is 0, or MUL is greater than DIV, `sample_en` and `bit_en` stay low.
- R8: A write to any of the three registers clears the accumulator phase and the prescaler count. Both strobes are low in the cycle after the write edge.
- R9: MUL and DIV accept values up to 2^24−1. Bits [31:24] of a MUL or DIV read are always zero, whatever was written there.
- R10: A read of any other offset returns zero. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |
| sample_en | output | 1 | Oversampling-rate strobe (Fref·MUL/DIV) |
| bit_en | output | 1 | Bit-rate strobe (sample rate / PS) |

## Verification
The hardest state to reach from the ports is a restart in the middle of a period: the accumulator holds a non-zero remainder and the prescaler count is partway through when a new register write arrives. The stimulus programs a slow ratio, lets a known number of additions build up the phase, and then rewrites the same divider. It then checks that the strobe counts over the next window match a zero-phase start rather than a continuation of the old phase. Ratios near the full 24-bit range and single-cycle ratios are also measured over exact windows, so that any off-by-one in the compare or the subtract changes the count.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;

    // Byte offsets of the configuration registers
    localparam logic [BUS_AW-1:0] OFS_PRESCALE = 8'h30;
    localparam logic [BUS_AW-1:0] OFS_MULT     = 8'h34;
    localparam logic [BUS_AW-1:0] OFS_DIVISOR  = 8'h38;

    // Phase accumulator states
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } acc_state_e;

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
    import frac_baud_pkg::*;
#(
    parameter int unsigned FRAC_W   = 24,
    parameter int unsigned PS_W     = 16,
    parameter int unsigned PS_RESET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [PS_W-1:0]   ps_q,
    output logic [FRAC_W-1:0] mul_q,
    output logic [FRAC_W-1:0] div_q,
    output logic              cfg_write
);

    logic hit_ps, hit_mul, hit_div, wr;

    always_comb begin
        hit_ps  = (bus_addr == OFS_PRESCALE);
        hit_mul = (bus_addr == OFS_MULT);
        hit_div = (bus_addr == OFS_DIVISOR);
        wr      = bus_sel && bus_we;
    end

    assign cfg_write = wr && (hit_ps || hit_mul || hit_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q  <= PS_W'(PS_RESET);
            mul_q <= FRAC_W'(1);
            div_q <= FRAC_W'(1);
        end else if (wr) begin
            if (hit_ps)  ps_q  <= bus_wdata[PS_W-1:0];
            if (hit_mul) mul_q <= bus_wdata[FRAC_W-1:0];
            if (hit_div) div_q <= bus_wdata[FRAC_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (hit_ps)  bus_rdata = BUS_DW'(ps_q);
            if (hit_mul) bus_rdata = BUS_DW'(mul_q);
            if (hit_div) bus_rdata = BUS_DW'(div_q);
        end
    end

endmodule

// File: rtl/frac_baud_accum.sv
module frac_baud_accum
    import frac_baud_pkg::*;
#(
    parameter int unsigned FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [FRAC_W-1:0] mul,
    input  logic [FRAC_W-1:0] div,
    output logic              tick
);

    localparam int unsigned SUM_W = FRAC_W + 1;

    acc_state_e state_q, state_d;
    logic [FRAC_W-1:0] phase_q;
    logic [SUM_W-1:0]  sum;
    logic              cfg_ok, wrap;

    always_comb begin
        cfg_ok = (mul != '0) && (div != '0) && (mul <= div);
        sum    = {1'b0, phase_q} + {1'b0, mul};
        wrap   = (sum >= {1'b0, div});
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_HALT;
        end else begin
            unique case (state_q)
                ST_HALT: if (cfg_ok)  state_d = ST_RUN;
                ST_RUN:  if (!cfg_ok) state_d = ST_HALT;
                default: state_d = ST_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // phase and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            tick    <= 1'b0;
        end else if (restart) begin
            phase_q <= '0;
            tick    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    phase_q <= '0;
                    tick    <= 1'b0;
                end
                ST_RUN: begin
                    if (!cfg_ok) begin
                        phase_q <= '0;
                        tick    <= 1'b0;
                    end else if (wrap) begin
                        phase_q <= FRAC_W'(sum - {1'b0, div});
                        tick    <= 1'b1;
                    end else begin
                        phase_q <= sum[FRAC_W-1:0];
                        tick    <= 1'b0;
                    end
                end
                default: begin
                    phase_q <= '0;
                    tick    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/frac_baud_prescale.sv
module frac_baud_prescale #(
    parameter int unsigned PS_W       = 16,
    parameter int unsigned PS_DEFAULT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    input  logic            tick_in,
    output logic            tick_out
);

    logic [PS_W-1:0] ps_eff, cnt_q;
    logic            last;

    always_comb begin
        ps_eff   = (ps == '0) ? PS_W'(PS_DEFAULT) : ps;
        last     = (cnt_q >= ps_eff - PS_W'(1));
        tick_out = tick_in && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (restart)    cnt_q <= '0;
        else if (tick_in)    cnt_q <= last ? '0 : cnt_q + PS_W'(1);
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int unsigned FRAC_W = 24,
    parameter int unsigned PS_W   = 16,
    parameter int unsigned PS_DEF = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sample_en,
    output logic        bit_en
);

    logic [PS_W-1:0]   cfg_ps;
    logic [FRAC_W-1:0] cfg_mul, cfg_div;
    logic              cfg_write;

    frac_baud_regs #(.FRAC_W(FRAC_W), .PS_W(PS_W), .PS_RESET(PS_DEF)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ps_q      (cfg_ps),
        .mul_q     (cfg_mul),
        .div_q     (cfg_div),
        .cfg_write (cfg_write)
    );

    frac_baud_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_write),
        .mul     (cfg_mul),
        .div     (cfg_div),
        .tick    (sample_en)
    );

    frac_baud_prescale #(.PS_W(PS_W), .PS_DEFAULT(PS_DEF)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cfg_write),
        .ps       (cfg_ps),
        .tick_in  (sample_en),
        .tick_out (bit_en)
    );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
    parameter int unsigned FRAC_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [FRAC_W-1:0] mul,
    input logic [FRAC_W-1:0] div,
    input logic              sample_en,
    input logic              bit_en
);

    logic any_cfg_wr;
    assign any_cfg_wr = bus_sel && bus_we &&
        (bus_addr == 8'h30 || bus_addr == 8'h34 || bus_addr == 8'h38);

    // R4
    bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> sample_en);

    // R7
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mul == '0) || (div == '0) || (mul > div)) |-> !sample_en);

    // R8
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_cfg_wr |=> (!sample_en && !bit_en));

    // R1
    mul_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 8'h34) |=> (mul == $past(bus_wdata[FRAC_W-1:0])));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_addr == 8'h34 || bus_addr == 8'h38)) |-> (bus_rdata[31:24] == 8'h00));

endmodule

bind frac_baud_gen frac_baud_chk #(.FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mul       (cfg_mul),
    .div       (cfg_div),
    .sample_en (sample_en),
    .bit_en    (bit_en)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sample_en, bit_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    frac_baud_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sample_en (sample_en),
        .bit_en    (bit_en)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Count strobes over W additions after the last write (R2, R3).
    task automatic measure(input string req, input int w,
                           input longint m, input longint dv, input longint ps);
        int s = 0, b = 0, both_bad = 0;
        longint es, eb, pe;
        for (int i = 0; i < w + 2; i++) begin
            @(negedge clk);
            if (sample_en) s++;
            if (bit_en) b++;
            if (bit_en && !sample_en) both_bad++;
        end
        es = (m == 0 || dv == 0 || m > dv) ? 0 : (longint'(w) * m) / dv;
        pe = (ps == 0) ? 16 : ps;
        eb = es / pe;
        check({req, " sample count"}, s, es);
        check({req, " bit count"}, b, eb);
        check({req, " R4 bit without sample"}, both_bad, 0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R6 sample low in reset", sample_en, 0);
        check("R6 bit low in reset", bit_en, 0);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h30, d); check("R6 PS reset", d, 16);
        rd(8'h34, d); check("R6 MUL reset", d, 1);
        rd(8'h38, d); check("R6 DIV reset", d, 1);
    endtask

    task automatic t_default_rate;
        wr(8'h30, 32'd16);
        measure("R2 R3 default", 64, 1, 1, 16);
    endtask

    task automatic t_fraction;
        wr(8'h34, 3); wr(8'h38, 7); wr(8'h30, 2);
        measure("R2 R3 3/7 ps2", 70, 3, 7, 2);
        wr(8'h30, 1); wr(8'h34, 5); wr(8'h38, 9);
        measure("R4 ps1 5/9", 90, 5, 9, 1);
    endtask

    task automatic t_ps_zero;
        logic [31:0] d;
        wr(8'h34, 1); wr(8'h38, 1); wr(8'h30, 0);
        measure("R5 ps zero", 80, 1, 1, 0);
        rd(8'h30, d); check("R5 ps reads 0", d, 0);
    endtask

    task automatic t_wide;
        logic [31:0] d;
        wr(8'h30, 3); wr(8'h38, 32'hFFFF_FFFF); wr(8'h34, 32'hAB12_3456);
        measure("R9 wide ratio", 400, 32'h12_3456, 32'hFF_FFFF, 3);
        rd(8'h34, d); check("R9 MUL upper zero", d, 32'h0012_3456);
        rd(8'h38, d); check("R9 DIV upper zero", d, 32'h00FF_FFFF);
        wr(8'h34, 32'hFF_FFFF); wr(8'h30, 1);
        measure("R9 full scale equal", 20, 32'hFF_FFFF, 32'hFF_FFFF, 1);
    endtask

    task automatic t_invalid;
        wr(8'h30, 1); wr(8'h34, 5); wr(8'h38, 4);
        measure("R7 mul>div", 40, 5, 4, 1);
        wr(8'h34, 0); wr(8'h38, 4);
        measure("R7 mul zero", 40, 0, 4, 1);
        wr(8'h34, 2); wr(8'h38, 0);
        measure("R7 div zero", 40, 2, 0, 1);
    endtask

    task automatic t_restart;
        wr(8'h30, 2); wr(8'h34, 1); wr(8'h38, 4);
        repeat (7) @(negedge clk);   // phase and prescaler mid-count
        wr(8'h38, 4);
        check("R8 strobe low after write", sample_en, 0);
        measure("R8 restart phase", 9, 1, 4, 2);
        repeat (5) @(negedge clk);
        wr(8'h30, 2);
        measure("R8 restart on PS write", 17, 1, 4, 2);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(8'h34, 7); wr(8'h38, 9); wr(8'h30, 4);
        wr(8'h3C, 32'h1234_5678);
        wr(8'h00, 32'h0000_0001);
        rd(8'h3C, d); check("R10 unmapped reads zero", d, 0);
        rd(8'h34, d); check("R10 MUL untouched", d, 7);
        rd(8'h38, d); check("R10 DIV untouched", d, 9);
        rd(8'h30, d); check("R1 PS readback", d, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_default_rate();
        t_fraction();
        t_ps_zero();
        t_wide();
        t_invalid();
        t_restart();
        t_unmapped();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule